// File: doc/BRIEF.md
# Standby Wake-Up Source Controller

This block decides when a system leaves its deepest standby state. It watches a set of asynchronous wake inputs. These can be external interrupt pins, bus line pins or supply-monitor interrupts. Each input can trigger on its rising edge or on its falling edge, chosen separately for each input. A matching edge latches a per-source flag. When a latched source is also enabled, the block ends deep standby. It then holds an internal system reset for a fixed return delay, followed by a further wait. After that it releases the system to restart.

Software reaches the block through a small register port. The port holds an enable word, a flag word, an edge-select word, a control word and a status word. The control word has a deep-standby request bit and a pad-retention bit. The retention bit freezes the pad states the block drives out. It is not cleared by the reset that the block raises on wake-up. Deep standby is refused, and ordinary standby is used instead, whenever either supply monitor is set to reset mode. The register port is a plain control interface with no flow control: a write takes effect at the clock edge where `reg_wr` is high, and `reg_rdata` follows `reg_addr` combinationally.

Top module: `ws_wake_ctrl`

## Requirements
- R1: A source's flag bit becomes 1 on its selected edge, whether or not the source is enabled. Edge-select bit 1 means rising and bit 0 means falling. The flag word is at address 1, the enable word at address 0 and the edge-select word at address 2.
- R2: An edge opposite to the selected one leaves the flag bit at 0.
- R3: Writing 0 to a flag bit clears it, and writing 1 has no effect. An edge that arrives in the same cycle as a clear wins, so the bit stays 1.
- R4: While in deep standby (`in_deep` = 1), a flagged source whose enable bit is 0 does not end standby, and `ds_rst` stays low.
- R5: When a source with both its flag and its enable set ends deep standby, `ds_rst` is high for exactly RET_CYC + WAIT_CYC consecutive cycles, and `in_deep` is then low.
- R6: Status bit 0 at address 4 (the wake-reset detect flag) becomes 1 on a deep-standby wake. It does not change on a wake from ordinary standby. Writing 0 clears it.
- R7: A pulse on `sleep_cmd` with control bit 0 (deep request, address 3) set enters deep standby, unless `mon1_rst_mode` or `mon2_rst_mode` is 1. In that case ordinary standby is entered (`in_soft` = 1).
- R8: A deep-standby wake clears the control deep-request bit. It keeps control bit 1 (retention), the enable word and the flag word.
- R9: While retention is 1, `pad_out` keeps the value of `port_cfg` from before retention was set. While retention is 0, `pad_out` equals `port_cfg`.
- R10: Ordinary standby ends when a flag and its matching enable are both set, without asserting `ds_rst`. A flagged but disabled source does not end it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold (power-on or pin) reset, active low |
| wake_src | input | NSRC | Asynchronous wake inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NSRC | Register write data |
| reg_rdata | output | NSRC | Register read data |
| sleep_cmd | input | 1 | One-cycle request to enter standby |
| mon1_rst_mode | input | 1 | Supply monitor 1 is configured for reset |
| mon2_rst_mode | input | 1 | Supply monitor 2 is configured for reset |
| port_cfg | input | PADW | Pad states from internal port configuration |
| pad_out | output | PADW | Pad states sent to the pads |
| in_deep | output | 1 | Deep standby active |
| in_soft | output | 1 | Ordinary standby active |
| ds_rst | output | 1 | Internal deep-standby system reset |
| wake_req | output | 1 | One-cycle pulse when any standby ends |

## Verification
Some properties are checked by assertions on every cycle:
- Flags never drop without a write to the flag word.
- Every edge hit lands in the flag word.
- A deep-standby wake always asserts the system reset.
- A request for standby made while a monitor is in reset mode never enters deep standby.
- Retained pads never move.

Other behaviour can only be shown by the bench's scenarios:
- The exact length of the reset pulse.
- The per-source edge polarity across all sixteen inputs.
- The same-cycle race between a clear and an edge.
- Which state survives the wake reset.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_EN   = 3'd0;
  localparam logic [AW-1:0] A_FLAG = 3'd1;
  localparam logic [AW-1:0] A_EDGE = 3'd2;
  localparam logic [AW-1:0] A_CTRL = 3'd3;
  localparam logic [AW-1:0] A_STAT = 3'd4;
  localparam int CTRL_DEEP = 0;
  localparam int CTRL_KEEP = 1;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_SOFT = 3'd1,
    ST_DEEP = 3'd2,
    ST_RETN = 3'd3,
    ST_HOLD = 3'd4
  } ws_state_e;
endpackage

// File: rtl/ws_edge_bank.sv
module ws_edge_bank #(
  parameter int NSRC = 16,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] rise_sel,
  output logic [NSRC-1:0] hit
);
  localparam int LAST = SYNC - 1;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [SYNC-1:0] sh;
    logic            prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[SYNC-2:0], src_in[g]};
        prev <= sh[LAST];
      end
    end
    assign hit[g] = rise_sel[g] ? (sh[LAST] & ~prev) : (~sh[LAST] & prev);
  end
endmodule

// File: rtl/ws_regfile.sv
module ws_regfile
  import ws_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  input  logic [NSRC-1:0] hit,
  input  logic            wake_deep,
  output logic [NSRC-1:0] en,
  output logic [NSRC-1:0] flag,
  output logic [NSRC-1:0] rise_sel,
  output logic            deep_req,
  output logic            keep
);
  logic            detect;
  logic [NSRC-1:0] clr;

  assign clr = (wr && addr == A_FLAG) ? ~wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= '0;
      flag     <= '0;
      rise_sel <= '0;
      deep_req <= 1'b0;
      keep     <= 1'b0;
      detect   <= 1'b0;
    end else begin
      flag <= (flag & ~clr) | hit;
      if (wr && addr == A_EN)   en       <= wdata;
      if (wr && addr == A_EDGE) rise_sel <= wdata;
      if (wr && addr == A_CTRL) keep     <= wdata[CTRL_KEEP];
      if (wake_deep)                      deep_req <= 1'b0;
      else if (wr && addr == A_CTRL)      deep_req <= wdata[CTRL_DEEP];
      if (wake_deep)                                 detect <= 1'b1;
      else if (wr && addr == A_STAT && !wdata[0])    detect <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_EN:    rdata = en;
      A_FLAG:  rdata = flag;
      A_EDGE:  rdata = rise_sel;
      A_CTRL:  rdata = {{(NSRC-2){1'b0}}, keep, deep_req};
      A_STAT:  rdata = {{(NSRC-1){1'b0}}, detect};
      default: rdata = '0;
    endcase
  end

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == A_FLAG) |=> ((flag & $past(flag)) == $past(flag)));

  p_hit_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((flag & $past(hit)) == $past(hit)));
endmodule

// File: rtl/ws_seq.sv
module ws_seq
  import ws_pkg::*;
#(
  parameter int RET_CYC  = 4,
  parameter int WAIT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_cmd,
  input  logic deep_req,
  input  logic mon1,
  input  logic mon2,
  input  logic wake_any,
  output logic wake_deep,
  output logic in_deep,
  output logic in_soft,
  output logic ds_rst,
  output logic wake_req
);
  localparam int MAXC = (RET_CYC > WAIT_CYC) ? RET_CYC : WAIT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RET_LD  = CW'(RET_CYC - 1);
  localparam logic [CW-1:0] WAIT_LD = CW'(WAIT_CYC - 1);

  ws_state_e     st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          wake_n;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    wake_n = 1'b0;
    case (st)
      ST_RUN: if (sleep_cmd) st_n = (deep_req && !mon1 && !mon2) ? ST_DEEP : ST_SOFT;
      ST_SOFT: if (wake_any) begin
        st_n   = ST_RUN;
        wake_n = 1'b1;
      end
      ST_DEEP: if (wake_any) begin
        st_n   = ST_RETN;
        cnt_n  = RET_LD;
        wake_n = 1'b1;
      end
      ST_RETN: if (cnt == '0) begin
        st_n  = ST_HOLD;
        cnt_n = WAIT_LD;
      end else cnt_n = cnt - 1'b1;
      ST_HOLD: if (cnt == '0) st_n = ST_RUN;
               else cnt_n = cnt - 1'b1;
      default: st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      cnt      <= '0;
      wake_req <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      wake_req <= wake_n;
    end
  end

  assign wake_deep = (st == ST_DEEP) && wake_any;
  assign in_deep   = (st == ST_DEEP);
  assign in_soft   = (st == ST_SOFT);
  assign ds_rst    = (st == ST_RETN) || (st == ST_HOLD);

  p_wake_resets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_deep && wake_any) |=> ds_rst);

  p_no_deep_mon_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_deep && !in_soft && !ds_rst && sleep_cmd && (mon1 || mon2)) |=> !in_deep);

  p_soft_no_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_soft |=> !ds_rst);
endmodule

// File: rtl/ws_pad_hold.sv
module ws_pad_hold #(
  parameter int PADW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            keep,
  input  logic [PADW-1:0] port_cfg,
  output logic [PADW-1:0] pad_out
);
  logic [PADW-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held <= '0;
    else if (!keep) held <= port_cfg;
  end

  assign pad_out = keep ? held : port_cfg;

  p_pads_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (keep && $past(keep)) |-> $stable(pad_out));
endmodule

// File: rtl/ws_wake_ctrl.sv
module ws_wake_ctrl
  import ws_pkg::*;
#(
  parameter int NSRC     = 16,
  parameter int PADW     = 16,
  parameter int SYNC     = 2,
  parameter int RET_CYC  = 4,
  parameter int WAIT_CYC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] wake_src,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  input  logic            sleep_cmd,
  input  logic            mon1_rst_mode,
  input  logic            mon2_rst_mode,
  input  logic [PADW-1:0] port_cfg,
  output logic [PADW-1:0] pad_out,
  output logic            in_deep,
  output logic            in_soft,
  output logic            ds_rst,
  output logic            wake_req
);
  logic [NSRC-1:0] hit, en, flag, rise_sel;
  logic            deep_req, keep, wake_deep, wake_any;

  assign wake_any = |(flag & en);

  ws_edge_bank #(.NSRC(NSRC), .SYNC(SYNC)) u_edges (
    .clk(clk), .rst_n(rst_n), .src_in(wake_src), .rise_sel(rise_sel), .hit(hit));

  ws_regfile #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .hit(hit), .wake_deep(wake_deep), .en(en), .flag(flag),
    .rise_sel(rise_sel), .deep_req(deep_req), .keep(keep));

  ws_seq #(.RET_CYC(RET_CYC), .WAIT_CYC(WAIT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .deep_req(deep_req),
    .mon1(mon1_rst_mode), .mon2(mon2_rst_mode), .wake_any(wake_any),
    .wake_deep(wake_deep), .in_deep(in_deep), .in_soft(in_soft),
    .ds_rst(ds_rst), .wake_req(wake_req));

  ws_pad_hold #(.PADW(PADW)) u_pads (
    .clk(clk), .rst_n(rst_n), .keep(keep), .port_cfg(port_cfg), .pad_out(pad_out));

  p_keep_survives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_rst && !reg_wr) |=> (keep == $past(keep)));
endmodule

// File: tb/ws_wake_ctrl_tb.sv
`timescale 1ns/1ps
module ws_wake_ctrl_tb;
  localparam int N = 16;
  localparam int RET = 4;
  localparam int WT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] wake_src = '0, reg_wdata = '0, reg_rdata;
  logic reg_wr = 1'b0, sleep_cmd = 1'b0, mon1 = 1'b0, mon2 = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [N-1:0] port_cfg = '0, pad_out;
  logic in_deep, in_soft, ds_rst, wake_req;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ws_wake_ctrl #(.NSRC(N), .PADW(N), .RET_CYC(RET), .WAIT_CYC(WT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wake_src(wake_src), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sleep_cmd(sleep_cmd), .mon1_rst_mode(mon1), .mon2_rst_mode(mon2),
    .port_cfg(port_cfg), .pad_out(pad_out), .in_deep(in_deep),
    .in_soft(in_soft), .ds_rst(ds_rst), .wake_req(wake_req));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic src(input int i, input logic v);
    @(negedge clk); wake_src[i] = v;
    repeat (6) @(posedge clk);
  endtask

  task automatic sleep_pulse();
    @(negedge clk); sleep_cmd = 1'b1;
    @(negedge clk); sleep_cmd = 1'b0;
    #1;
  endtask

  task automatic count_rst(input int win, output int n);
    n = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk); #1;
      if (ds_rst) n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); chk("reset regs R1", 32'(d), 0);
    end
    chk("reset ds_rst R5", 32'(ds_rst), 0);
    chk("reset pads R9", 32'(pad_out), 32'(port_cfg));

    // R1 R2 R3: sweep every source and both polarities, sources disabled
    for (int e = 0; e < 2; e++) begin
      wr(3'd2, e[0] ? '1 : '0);
      for (int i = 0; i < N; i++) begin
        src(i, 1'b1);
        rd(3'd1, d); chk(e[0] ? "rise sets R1" : "rise ignored R2", 32'(d), e[0] ? 32'(1 << i) : 0);
        src(i, 1'b0);
        rd(3'd1, d); chk(e[0] ? "fall ignored R2" : "fall sets R1", 32'(d), 32'(1 << i));
        wr(3'd1, '0);
        rd(3'd1, d); chk("clear R3", 32'(d), 0);
      end
    end

    // R3: write 1 no effect, clear racing an edge
    wr(3'd2, '1);
    src(5, 1'b1);
    rd(3'd1, d); chk("flag5 R1", 32'(d), 32'h20);
    wr(3'd1, '1);
    rd(3'd1, d); chk("write one keeps R3", 32'(d), 32'h20);
    @(negedge clk); wake_src[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(3'd1, '0);
    rd(3'd1, d); chk("edge beats clear R3", 32'(d), 32'h04);
    src(5, 1'b0); src(2, 1'b0);
    wr(3'd1, '0);

    // deep standby with retention
    wr(3'd0, 16'h0001);
    @(negedge clk); port_cfg = 16'hA5A5;
    wr(3'd3, 16'h0003);
    @(negedge clk); port_cfg = 16'h1234;
    repeat (2) @(negedge clk);
    chk("pads frozen R9", 32'(pad_out), 32'hA5A5);
    sleep_pulse();
    chk("deep entered R7", 32'(in_deep), 1);
    src(4, 1'b1);
    chk("disabled stays deep R4", 32'(in_deep), 1);
    chk("disabled no reset R4", 32'(ds_rst), 0);
    @(negedge clk); wake_src[0] = 1'b1;
    count_rst(30, n);
    chk("reset length R5", 32'(n), RET + WT);
    chk("left deep R5", 32'(in_deep), 0);
    rd(3'd4, d); chk("detect set R6", 32'(d), 1);
    rd(3'd3, d); chk("ctrl after wake R8", 32'(d), 2);
    rd(3'd0, d); chk("enable kept R8", 32'(d), 1);
    rd(3'd1, d); chk("flags kept R8", 32'(d), 32'h11);
    chk("pads still frozen R9", 32'(pad_out), 32'hA5A5);
    wr(3'd3, '0);
    chk("pads released R9", 32'(pad_out), 32'h1234);
    src(0, 1'b0); src(4, 1'b0);
    wr(3'd1, '0); wr(3'd4, '0);
    rd(3'd4, d); chk("detect cleared R6", 32'(d), 0);

    // R7 R10: monitors force ordinary standby
    for (int m = 0; m < 2; m++) begin
      @(negedge clk); mon1 = (m == 0); mon2 = (m == 1);
      wr(3'd3, 16'h0001);
      sleep_pulse();
      chk("deep refused R7", 32'(in_deep), 0);
      chk("soft used R7", 32'(in_soft), 1);
      src(4, 1'b1);
      chk("disabled keeps soft R10", 32'(in_soft), 1);
      @(negedge clk); wake_src[0] = 1'b1;
      count_rst(20, n);
      chk("soft wake no reset R10", 32'(n), 0);
      chk("soft left R10", 32'(in_soft), 0);
      rd(3'd4, d); chk("no detect on soft R6", 32'(d), 0);
      src(0, 1'b0); src(4, 1'b0);
      wr(3'd1, '0); wr(3'd3, '0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule